// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block forms the data-memory address for an 8-bit accumulator-style core. Each cycle it takes the file operand from the instruction word, an access select bit, an indirect request and a set of pointer register values. From these it drives a 12-bit effective address. It also raises a flag when that address falls in the special-function-register region at the top of data space.

Direct accesses are formed in one of two ways. An access through the fixed access window reaches the bottom 128 bytes of RAM and the top 128 bytes of data space without using the bank register. Every other direct access joins the bank register below the operand. Indirect accesses ignore the operand and use the low 12 bits of the selected pointer.

The bank register belongs to this block. It is loaded through a write-enable pulse, and the new value applies from the following instruction. The address path is purely combinational from the current bank value and the inputs.

Top module: `banked_addr_gen`

## Requirements
- R1: After reset the bank register is 0, so a banked direct access with operand 0x34 yields address 0x034.
- R2: With acc_sel=0 and ind_req=0, eff_addr = {bank[3:0], file_opd[7:0]}.
- R3: With bank 0x1 loaded, banked operands 0x00 and 0xFF give addresses 0x100 and 0x1FF.
- R4: With acc_sel=1 and ind_req=0, operands 0x00..0x7F give addresses 0x000..0x07F, whatever the bank register holds.
- R5: With acc_sel=1 and ind_req=0, operands 0x80..0xFF give addresses 0xF80..0xFFF, whatever the bank register holds.
- R6: When bank_we is high at a rising clock edge, bank_wdata is loaded and used from the next cycle on. In the cycle of the write the old bank is still used. With bank_we low the bank register holds its value.
- R7: With ind_req=1, eff_addr comes from pointer ptr_sel (ptr_vals index 0..2), and file_opd, acc_sel and the bank register have no effect. A ptr_sel code of 3 selects pointer 0.
- R8: Pointer bits 15..12 are ignored: eff_addr takes only pointer bits 11..0.
- R9: sfr_space is 1 exactly when eff_addr >= 0xF80, whether the address was formed by the access window, by bank 0xF, or by a pointer. At 0xF7F it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 4 | Value to load into the bank register |
| file_opd | input | 8 | File operand from the instruction word |
| acc_sel | input | 1 | 1: use the fixed access window, 0: use the bank register |
| ind_req | input | 1 | 1: take the address from a pointer |
| ptr_sel | input | 2 | Pointer index for indirect accesses |
| ptr_vals | input | 3x16 | Pointer register values, index 0 in the low word |
| eff_addr | output | 12 | Effective data address |
| sfr_space | output | 1 | Effective address is in the special-function region |

## Verification
The bench targets the access window split at operand 0x7F/0x80 with a non-zero bank loaded. A design that ignored the access bit there would leak the bank into the address, and one that split the window wrongly would map 0x80 into low RAM. The bench checks the address in the same cycle as a bank write and again in the next one. This catches a bank register that is bypassed early or that is never updated. It drives pointers with junk in their upper nibble and uses the unused select code to catch pointer truncation and decode faults. It probes 0xF7F against 0xF80 through all three address paths to catch an off-by-one in the special-region compare.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

    // Which path produced the effective address
    typedef enum logic [1:0] {
        SRC_BANKED   = 2'd0,
        SRC_ACC_LOW  = 2'd1,
        SRC_ACC_HIGH = 2'd2,
        SRC_POINTER  = 2'd3
    } dmag_src_e;

endpackage

// File: rtl/dmag_bank_reg.sv
module dmag_bank_reg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.bank = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank_q = state_q.bank;

    // R6: a write lands on the next cycle
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (bank_q == $past(wdata)));

    // R6: without a write the bank holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank_q));

endmodule

// File: rtl/dmag_direct_map.sv
module dmag_direct_map
    import dmag_pkg::*;
#(
    parameter int OPD_W  = 8,
    parameter int BANK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OPD_W-1:0]        opd,
    input  logic                    acc_sel,
    input  logic [BANK_W-1:0]       bank,
    output logic [BANK_W+OPD_W-1:0] addr,
    output dmag_src_e               src
);

    localparam int ADDR_W = BANK_W + OPD_W;
    localparam int HALF_W = OPD_W - 1;

    logic window_high;

    assign window_high = opd[OPD_W-1];

    always_comb begin
        if (!acc_sel) begin
            src  = SRC_BANKED;
            addr = {bank, opd};
        end else if (window_high) begin
            src  = SRC_ACC_HIGH;
            addr = {{(ADDR_W-HALF_W){1'b1}}, opd[HALF_W-1:0]};
        end else begin
            src  = SRC_ACC_LOW;
            addr = {{(ADDR_W-HALF_W){1'b0}}, opd[HALF_W-1:0]};
        end
    end

    // R4: low half of the access window is bank-independent
    a_r4_low_window: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && !opd[OPD_W-1]) |-> (addr[ADDR_W-1:HALF_W] == '0));

    // R5: high half of the access window lands in the top region
    a_r5_high_window: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && opd[OPD_W-1]) |-> (&addr[ADDR_W-1:HALF_W]));

    // R2: banked mode keeps the operand in the low byte
    a_r2_banked_low: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_sel |-> (addr[OPD_W-1:0] == opd && addr[ADDR_W-1:OPD_W] == bank));

endmodule

// File: rtl/dmag_ptr_mux.sv
module dmag_ptr_mux #(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 16,
    parameter int NPTR   = 3,
    parameter int SEL_W  = 2
) (
    input  logic [NPTR-1:0][PTR_W-1:0] ptr_vals,
    input  logic [SEL_W-1:0]           sel,
    output logic [ADDR_W-1:0]          ptr_addr
);

    logic [NPTR-1:0][ADDR_W-1:0] trunc;

    genvar g;
    generate
        for (g = 0; g < NPTR; g++) begin : g_trunc
            assign trunc[g] = ptr_vals[g][ADDR_W-1:0];
        end
    endgenerate

    // Unused select codes fall back to pointer 0
    always_comb begin
        ptr_addr = trunc[0];
        for (int i = 1; i < NPTR; i++) begin
            if (sel == SEL_W'(i)) begin
                ptr_addr = trunc[i];
            end
        end
    end

endmodule

// File: rtl/banked_addr_gen.sv
module banked_addr_gen
    import dmag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OPD_W  = 8,
    parameter int PTR_W  = 16,
    parameter int NPTR   = 3,
    parameter int SEL_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bank_we,
    input  logic [ADDR_W-OPD_W-1:0]     bank_wdata,
    input  logic [OPD_W-1:0]            file_opd,
    input  logic                        acc_sel,
    input  logic                        ind_req,
    input  logic [SEL_W-1:0]            ptr_sel,
    input  logic [NPTR-1:0][PTR_W-1:0]  ptr_vals,
    output logic [ADDR_W-1:0]           eff_addr,
    output logic                        sfr_space
);

    localparam int BANK_W = ADDR_W - OPD_W;
    localparam logic [ADDR_W-1:0] SFR_BASE = ~(ADDR_W'((1 << (OPD_W-1)) - 1));

    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] direct_addr;
    logic [ADDR_W-1:0] ptr_addr;
    dmag_src_e         direct_src;
    dmag_src_e         src;

    dmag_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bank_we),
        .wdata  (bank_wdata),
        .bank_q (bank_q)
    );

    dmag_direct_map #(.OPD_W(OPD_W), .BANK_W(BANK_W)) u_direct (
        .clk     (clk),
        .rst_n   (rst_n),
        .opd     (file_opd),
        .acc_sel (acc_sel),
        .bank    (bank_q),
        .addr    (direct_addr),
        .src     (direct_src)
    );

    dmag_ptr_mux #(
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W),
        .NPTR   (NPTR),
        .SEL_W  (SEL_W)
    ) u_ptr (
        .ptr_vals (ptr_vals),
        .sel      (ptr_sel),
        .ptr_addr (ptr_addr)
    );

    always_comb begin
        if (ind_req) begin
            src      = SRC_POINTER;
            eff_addr = ptr_addr;
        end else begin
            src      = direct_src;
            eff_addr = direct_addr;
        end
        sfr_space = (eff_addr >= SFR_BASE);
    end

    // R7: pointer 0 drives the address, operand ignored
    a_r7_ptr0: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req && ptr_sel == '0) |-> (eff_addr == ptr_vals[0][ADDR_W-1:0]));

    // R7: indirect source wins over any direct setting
    a_r7_src_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req |-> (src == SRC_POINTER));

    // R9: flag only when the upper address bits are all ones
    a_r9_sfr_region: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_space |-> (&eff_addr[ADDR_W-1:OPD_W-1]));

    // R9: access-window high half always flags the special region
    a_r9_acc_high_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!ind_req && acc_sel && file_opd[OPD_W-1]) |-> sfr_space);

endmodule

// File: tb/banked_addr_gen_tb.sv
module banked_addr_gen_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bank_we = 1'b0;
    logic [3:0]        bank_wdata = '0;
    logic [7:0]        file_opd = '0;
    logic              acc_sel = 1'b0;
    logic              ind_req = 1'b0;
    logic [1:0]        ptr_sel = '0;
    logic [2:0][15:0]  ptr_vals = '0;
    logic [11:0]       eff_addr;
    logic              sfr_space;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    banked_addr_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .file_opd   (file_opd),
        .acc_sel    (acc_sel),
        .ind_req    (ind_req),
        .ptr_sel    (ptr_sel),
        .ptr_vals   (ptr_vals),
        .eff_addr   (eff_addr),
        .sfr_space  (sfr_space)
    );

    task automatic chk(input string req, input logic [11:0] exp_a, input logic exp_s);
        checks++;
        if (eff_addr !== exp_a || sfr_space !== exp_s) begin
            fails++;
            $display("FAIL %s: addr=%h sfr=%b expected addr=%h sfr=%b",
                     req, eff_addr, sfr_space, exp_a, exp_s);
        end
    endtask

    function automatic logic sfr_of(input logic [11:0] a);
        return a >= 12'hF80;
    endfunction

    task automatic direct(input logic a, input logic [7:0] o);
        @(negedge clk);
        ind_req = 1'b0; acc_sel = a; file_opd = o;
        #1;
    endtask

    task automatic load_bank(input logic [3:0] b);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = b;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    task automatic t_reset();
        direct(1'b0, 8'h34);
        chk("R1", 12'h034, 1'b0);
    endtask

    task automatic t_bank_one();
        load_bank(4'h1);
        direct(1'b0, 8'h00); chk("R3", 12'h100, 1'b0);
        direct(1'b0, 8'hFF); chk("R3", 12'h1FF, 1'b0);
    endtask

    task automatic t_banked_patterns();
        load_bank(4'h9);
        direct(1'b0, 8'h5A); chk("R2", 12'h95A, 1'b0);
        load_bank(4'hF);
        direct(1'b0, 8'h7F); chk("R9", 12'hF7F, 1'b0);
        direct(1'b0, 8'h80); chk("R9", 12'hF80, 1'b1);
    endtask

    task automatic t_access_window();
        load_bank(4'h6);
        direct(1'b1, 8'h00); chk("R4", 12'h000, 1'b0);
        direct(1'b1, 8'h7F); chk("R4", 12'h07F, 1'b0);
        direct(1'b1, 8'h80); chk("R5", 12'hF80, 1'b1);
        direct(1'b1, 8'hFF); chk("R5", 12'hFFF, 1'b1);
        direct(1'b1, 8'hC3); chk("R5", 12'hFC3, 1'b1);
    endtask

    task automatic t_write_timing();
        load_bank(4'h2);
        @(negedge clk);
        acc_sel = 1'b0; ind_req = 1'b0; file_opd = 8'h11;
        bank_we = 1'b1; bank_wdata = 4'hA;
        #1;
        chk("R6 same cycle", 12'h211, 1'b0);
        @(negedge clk);
        bank_we = 1'b0; bank_wdata = 4'h3;
        #1;
        chk("R6 next cycle", 12'hA11, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 hold", 12'hA11, 1'b0);
    endtask

    task automatic t_indirect();
        ptr_vals[0] = 16'hB123;
        ptr_vals[1] = 16'h4F80;
        ptr_vals[2] = 16'hFF7F;
        load_bank(4'h5);
        @(negedge clk);
        ind_req = 1'b1; acc_sel = 1'b1; file_opd = 8'hEE;
        for (int s = 0; s < 4; s++) begin
            logic [11:0] e;
            ptr_sel = 2'(s);
            #1;
            e = (s == 3) ? 12'h123 : ptr_vals[s][11:0];
            chk((s == 3) ? "R7 sel3" : "R7/R8", e, sfr_of(e));
            #1;
        end
        ptr_sel = 2'd0; acc_sel = 1'b0; file_opd = 8'h01;
        #1;
        chk("R7 operand ignored", 12'h123, 1'b0);
        ptr_sel = 2'd1;
        #1;
        chk("R9 pointer", 12'hF80, 1'b1);
        ind_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank_one();
        t_banked_patterns();
        t_access_window();
        t_write_timing();
        t_indirect();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule